// File: doc/BRIEF.md
# Chainable Multi-Channel Periodic Timer

This block holds a set of periodic down-counters, all clocked by the bus clock with no prescaler. Each channel counts down from a programmed reload value. When it passes zero, it sets a sticky expiry flag and emits a one-cycle trigger pulse, for example to start a converter. A channel can drive its interrupt line while its flag is set, as long as its interrupt enable is on.

Any channel except the first can be set to chain mode. In chain mode it no longer counts clock cycles. It steps once each time the channel just below it expires, so the pair acts as a single timer twice as wide. Software sees a flat register space. A register address is formed from the channel number in the upper bits and a two-bit register selector in the lower bits. Writes and reads each have their own address, and read data is registered.

Top module: `cascade_timer`

## Requirements
- R1: After reset, every channel's reload value, count, control bits and flag read as zero, and all irq and trig outputs are low.
- R2: A write that sets the run bit of a stopped channel loads the count from the reload value on that write's clock edge. After that, an unchained running channel's count drops by one on every clock.
- R3: A running channel whose count is zero reloads it from the reload value on its next step and sets its flag. Its trig bit is then high for exactly the cycle after that edge. With reload value L, an unchained channel fires every L+1 cycles, and the first pulse comes L+2 cycles after the enabling write cycle.
- R4: The trig pulse and the flag do not depend on the interrupt enable; with the enable clear the irq bit stays low.
- R5: irq of a channel is high exactly when its flag and interrupt enable (control bit 1) are both set. Writing 1 to flag bit 0 clears the flag, and writing 0 leaves it unchanged. A new expiry on the same edge as a clear keeps the flag set.
- R6: For a channel above channel 0 with chain (control bit 2) set, the count changes only on clock edges where the channel below expires. With reload values Lhi and Llo, the pair's period is (Lhi+1)*(Llo+1) cycles.
- R7: The chain bit of channel 0 is stored but has no effect: channel 0 always counts every clock.
- R8: Writing a reload value to a running channel does not change its current count. The new value is first used at the next reload. Clearing and then setting the run bit restarts the count from the new value.
- R9: A channel with the run bit (control bit 0) clear holds its count and produces no expiry.
- R10: Register address = channel*4 + selector, with selector 0 = reload value, 1 = current count (read-only), 2 = control, 3 = flag. rd_data shows the register addressed by rd_addr in the previous cycle, with the state as of that previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (channel, selector) |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | ADDR_W | Read address (channel, selector) |
| rd_data | output | CNT_W | Registered read data |
| irq | output | NUM_CH | Per-channel interrupt level |
| trig | output | NUM_CH | Per-channel one-cycle expiry pulse |

## Verification
The checker covers the relations that hold in every cycle. It checks that an interrupt only appears with its flag and enable, and that a trigger implies a set flag and a running channel. It also checks that an unchained running count steps down by exactly one, and that a chained count holds in every cycle in which its lower neighbour does not expire. The exact cycles of the pulses cannot be seen from one cycle to the next, so only the bench scenarios can show them. This includes the period of a chained pair, a reload value taking effect only at the next reload, the restart after a stop and start, and the channel 0 chain bit having no effect. The same holds for write-one-to-clear, since it depends on a write sequence.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RELOAD = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_FLAG   = 2'd3
  } reg_sel_e;

  localparam int CTL_RUN   = 0;
  localparam int CTL_IE    = 1;
  localparam int CTL_CHAIN = 2;
  localparam int CTL_W     = 3;

  typedef struct packed {
    logic chain;
    logic ie;
    logic run;
  } chan_ctrl_t;

endpackage

// File: rtl/cascade_timer_chan.sv
module cascade_timer_chan
  import cascade_timer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter bit CAN_CHAIN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload_we,
  input  logic             ctrl_we,
  input  logic             flag_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             below_evt,
  output logic             evt_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o,
  output chan_ctrl_t       ctrl_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             trig_o
);

  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;
  chan_ctrl_t       ctrl_q;
  chan_ctrl_t       ctrl_d;
  logic             flag_q;
  logic             flag_d;
  logic             irq_q;
  logic             trig_q;
  logic             chained;
  logic             step;
  logic             evt;
  logic             start;

  // channel 0 is built with CAN_CHAIN = 0, so its chain bit is inert
  assign chained = CAN_CHAIN && ctrl_q.chain;
  assign step    = ctrl_q.run && (chained ? below_evt : 1'b1);
  assign evt     = step && (count_q == '0);
  assign start   = ctrl_we && wdata[CTL_RUN] && !ctrl_q.run;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = chan_ctrl_t'(wdata[CTL_W-1:0]);
  end

  // expiry wins over a simultaneous write-one-to-clear
  assign flag_d = evt || (flag_q && !(flag_we && wdata[0]));

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      count_q  <= '0;
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
      trig_q   <= 1'b0;
    end else begin
      if (reload_we) reload_q <= wdata;
      ctrl_q <= ctrl_d;
      if (start)     count_q <= reload_q;
      else if (evt)  count_q <= reload_q;
      else if (step) count_q <= count_q - 1'b1;
      flag_q <= flag_d;
      irq_q  <= flag_d && ctrl_d.ie;
      trig_q <= evt;
    end
  end

  assign evt_o    = evt;
  assign count_o  = count_q;
  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;
  assign flag_o   = flag_q;
  assign irq_o    = irq_q;
  assign trig_o   = trig_q;

endmodule

// File: rtl/cascade_timer_regs.sv
module cascade_timer_regs
  import cascade_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  reload_all [NUM_CH],
  input  logic [CNT_W-1:0]  count_all  [NUM_CH],
  input  chan_ctrl_t        ctrl_all   [NUM_CH],
  input  logic [NUM_CH-1:0] flag_all,
  output logic [NUM_CH-1:0] reload_we,
  output logic [NUM_CH-1:0] ctrl_we,
  output logic [NUM_CH-1:0] flag_we,
  output logic [CNT_W-1:0]  rd_data
);

  logic [CH_W-1:0] wr_ch;
  reg_sel_e        wr_sel;
  logic [CH_W-1:0] rd_ch;
  reg_sel_e        rd_sel;
  logic [CNT_W-1:0] rd_next;

  assign wr_ch  = wr_addr[ADDR_W-1:SEL_W];
  assign wr_sel = reg_sel_e'(wr_addr[SEL_W-1:0]);
  assign rd_ch  = rd_addr[ADDR_W-1:SEL_W];
  assign rd_sel = reg_sel_e'(rd_addr[SEL_W-1:0]);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
      logic hit;
      assign hit          = wr_en && (wr_ch == CH_W'(i));
      assign reload_we[i] = hit && (wr_sel == SEL_RELOAD);
      assign ctrl_we[i]   = hit && (wr_sel == SEL_CTRL);
      assign flag_we[i]   = hit && (wr_sel == SEL_FLAG);
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_ch == CH_W'(i)) begin
        case (rd_sel)
          SEL_RELOAD: rd_next = reload_all[i];
          SEL_COUNT:  rd_next = count_all[i];
          SEL_CTRL:   rd_next = {{(CNT_W-CTL_W){1'b0}}, ctrl_all[i]};
          SEL_FLAG:   rd_next = {{(CNT_W-1){1'b0}}, flag_all[i]};
          default:    rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import cascade_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [NUM_CH-1:0] irq,
  output logic [NUM_CH-1:0] trig
);

  logic [CNT_W-1:0]  reload_all [NUM_CH];
  logic [CNT_W-1:0]  count_all  [NUM_CH];
  chan_ctrl_t        ctrl_all   [NUM_CH];
  logic [NUM_CH-1:0] flag_all;
  logic [NUM_CH-1:0] evt_all;
  logic [NUM_CH-1:0] below_all;
  logic [NUM_CH-1:0] run_all;
  logic [NUM_CH-1:0] ie_all;
  logic [NUM_CH-1:0] chain_all;
  logic [NUM_CH-1:0] reload_we;
  logic [NUM_CH-1:0] ctrl_we;
  logic [NUM_CH-1:0] flag_we;

  cascade_timer_regs #(
    .NUM_CH(NUM_CH),
    .CNT_W (CNT_W)
  ) regs_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .reload_all(reload_all),
    .count_all (count_all),
    .ctrl_all  (ctrl_all),
    .flag_all  (flag_all),
    .reload_we (reload_we),
    .ctrl_we   (ctrl_we),
    .flag_we   (flag_we),
    .rd_data   (rd_data)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      if (i == 0) begin : g_head
        assign below_all[i] = 1'b0;
      end else begin : g_link
        assign below_all[i] = evt_all[i-1];
      end

      cascade_timer_chan #(
        .CNT_W    (CNT_W),
        .CAN_CHAIN(i != 0)
      ) chan_i (
        .clk      (clk),
        .rst      (rst),
        .reload_we(reload_we[i]),
        .ctrl_we  (ctrl_we[i]),
        .flag_we  (flag_we[i]),
        .wdata    (wr_data),
        .below_evt(below_all[i]),
        .evt_o    (evt_all[i]),
        .count_o  (count_all[i]),
        .reload_o (reload_all[i]),
        .ctrl_o   (ctrl_all[i]),
        .flag_o   (flag_all[i]),
        .irq_o    (irq[i]),
        .trig_o   (trig[i])
      );

      assign run_all[i]   = ctrl_all[i].run;
      assign ie_all[i]    = ctrl_all[i].ie;
      assign chain_all[i] = ctrl_all[i].chain;
    end
  endgenerate

endmodule

// File: rtl/cascade_timer_chk.sv
module cascade_timer_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] trig,
  input logic [NUM_CH-1:0] run_all,
  input logic [NUM_CH-1:0] ie_all,
  input logic [NUM_CH-1:0] chain_all,
  input logic [NUM_CH-1:0] flag_all,
  input logic [NUM_CH-1:0] evt_all,
  input logic [CNT_W-1:0]  count_all [NUM_CH]
);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_p
      // R5: interrupt only with flag and enable
      p_irq_source_r5: assert property (@(posedge clk) disable iff (rst)
        irq[i] |-> (flag_all[i] && ie_all[i]));

      // R3: a trigger pulse coincides with a set flag
      p_trig_sets_flag_r3: assert property (@(posedge clk) disable iff (rst)
        trig[i] |-> flag_all[i]);

      // R9: no pulse from a channel that was stopped
      p_trig_needs_run_r9: assert property (@(posedge clk) disable iff (rst)
        trig[i] |-> $past(run_all[i]));

      if (i == 0) begin : g_c0
        // R2, R7: channel 0 steps every clock regardless of its chain bit
        p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
          (run_all[i] && count_all[i] != '0) |=> (count_all[i] == $past(count_all[i]) - 1'b1));
      end else begin : g_cn
        // R2: unchained running count steps down by one
        p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
          (run_all[i] && !chain_all[i] && count_all[i] != '0)
          |=> (count_all[i] == $past(count_all[i]) - 1'b1));
        // R6: chained count holds unless the lower channel expires
        p_chain_hold_r6: assert property (@(posedge clk) disable iff (rst)
          (run_all[i] && chain_all[i] && !evt_all[i-1]) |=> $stable(count_all[i]));
      end
    end
  endgenerate

endmodule

bind cascade_timer cascade_timer_chk #(
  .NUM_CH(NUM_CH),
  .CNT_W (CNT_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq),
  .trig     (trig),
  .run_all  (run_all),
  .ie_all   (ie_all),
  .chain_all(chain_all),
  .flag_all (flag_all),
  .evt_all  (evt_all),
  .count_all(count_all)
);

// File: tb/cascade_timer_tb_top.sv
module cascade_timer_tb_top;
  localparam int NUM_CH = 4;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 4;
  localparam int S_RELOAD = 0, S_COUNT = 1, S_CTRL = 2, S_FLAG = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0]  wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [CNT_W-1:0]  rd_data;
  logic [NUM_CH-1:0] irq;
  logic [NUM_CH-1:0] trig;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cascade_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .trig(trig)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // scoreboard monitor: every observed pulse must match a queued expectation
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (trig[i]) begin
          int key;
          int idx;
          key = cyc * 8 + i;
          idx = -1;
          foreach (exp_q[j]) if (exp_q[j] == key && idx < 0) idx = j;
          n_chk++;
          if (idx < 0) begin
            n_bad++;
            $display("FAIL R3 ch%0d: actual=pulse at cycle %0d expected=no pulse", i, cyc);
          end else exp_q.delete(idx);
        end
      end
    end
  end

  task automatic plan(input int ch, input int first, input int per, input int last);
    for (int t = first; t <= last; t += per) exp_q.push_back(t * 8 + ch);
  endtask

  task automatic drain(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic wr(input int ch, input int sel, input logic [CNT_W-1:0] d);
    wr_en = 1'b1; wr_addr = ADDR_W'(ch * 4 + sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int sel, output logic [CNT_W-1:0] v);
    rd_addr = ADDR_W'(ch * 4 + sel);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  function automatic int exp_cnt(input int l, input int en_edge, input int c);
    return l - ((c - en_edge) % (l + 1));
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] v, v2;
    int k, stop;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 / R10: reset state over the whole register space
    chk(irq == '0, "R1 irq", irq, 0);
    chk(trig == '0, "R1 trig", trig, 0);
    for (int c = 0; c < NUM_CH; c++)
      for (int s = 0; s < 4; s++) begin
        rd(c, s, v);
        chk(v == '0, "R1 R10 reset readback", v, 0);
      end

    // R3 R2 R5: channel 0, reload 9, interrupt enabled
    wr(0, S_RELOAD, 9);
    rd(0, S_RELOAD, v);
    chk(v == 9, "R10 reload readback", v, 9);
    k = cyc; stop = k + 45;
    plan(0, k + 11, 10, stop + 1);
    wr(0, S_CTRL, 3);
    rd(0, S_CTRL, v);
    chk(v == 3, "R10 ctrl readback", v, 3);
    wait_to(k + 23);
    rd(0, S_COUNT, v);
    chk(v == CNT_W'(exp_cnt(9, k + 1, k + 23)), "R2 count", v, exp_cnt(9, k + 1, k + 23));
    rd(0, S_COUNT, v);
    chk(v == CNT_W'(exp_cnt(9, k + 1, k + 24)), "R2 decrement", v, exp_cnt(9, k + 1, k + 24));
    chk(irq[0] == 1'b1, "R5 irq after expiry", irq[0], 1);
    wait_to(stop);
    wr(0, S_CTRL, 2);
    repeat (3) @(negedge clk);
    drain("R3 missing pulses ch0");
    rd(0, S_COUNT, v);
    repeat (5) @(negedge clk);
    rd(0, S_COUNT, v2);
    chk(v == v2, "R9 stopped count holds", v2, v);
    wr(0, S_FLAG, 0);
    chk(irq[0] == 1'b1, "R5 write 0 keeps flag", irq[0], 1);
    wr(0, S_FLAG, 1);
    chk(irq[0] == 1'b0, "R5 write 1 clears", irq[0], 0);
    rd(0, S_FLAG, v);
    chk(v == 0, "R5 flag cleared", v, 0);

    // R4: channel 1 without interrupt enable
    wr(1, S_RELOAD, 4);
    k = cyc; stop = k + 30;
    plan(1, k + 6, 5, stop + 1);
    wr(1, S_CTRL, 1);
    wait_to(k + 20);
    chk(irq[1] == 1'b0, "R4 irq stays low", irq[1], 0);
    wait_to(stop);
    wr(1, S_CTRL, 0);
    repeat (3) @(negedge clk);
    drain("R4 missing pulses ch1");
    rd(1, S_FLAG, v);
    chk(v == 1, "R4 flag set without enable", v, 1);
    wr(1, S_FLAG, 1);

    // R6: channel 1 chained on channel 0
    wr(0, S_RELOAD, 3);
    wr(1, S_RELOAD, 2);
    wr(1, S_CTRL, 5);
    k = cyc; stop = k + 50;
    plan(0, k + 5, 4, stop + 1);
    plan(1, k + 13, 12, stop + 1);
    wr(0, S_CTRL, 1);
    wait_to(k + 7);
    rd(1, S_COUNT, v);
    chk(v == 1, "R6 chained step", v, 1);
    rd(1, S_COUNT, v);
    chk(v == 1, "R6 chained hold", v, 1);
    wait_to(stop);
    wr(0, S_CTRL, 0);
    wr(1, S_CTRL, 0);
    repeat (3) @(negedge clk);
    drain("R6 missing pulses chain");

    // R7: chain bit on channel 0 has no effect
    wr(0, S_RELOAD, 2);
    k = cyc; stop = k + 20;
    plan(0, k + 4, 3, stop + 1);
    wr(0, S_CTRL, 5);
    wait_to(stop);
    wr(0, S_CTRL, 0);
    repeat (3) @(negedge clk);
    drain("R7 missing pulses ch0 chain");

    // R8: reload change while running, then restart
    wr(2, S_RELOAD, 7);
    k = cyc; stop = k + 30;
    plan(2, k + 9, 100, k + 9);
    plan(2, k + 12, 3, stop + 1);
    wr(2, S_CTRL, 1);
    wait_to(k + 3);
    wr(2, S_RELOAD, 2);
    wait_to(k + 5);
    rd(2, S_COUNT, v);
    chk(v == 3, "R8 count not restarted", v, 3);
    wait_to(stop);
    wr(2, S_CTRL, 0);
    wr(2, S_RELOAD, 5);
    k = cyc; stop = k + 20;
    plan(2, k + 7, 6, stop + 1);
    wr(2, S_CTRL, 1);
    wait_to(stop);
    wr(2, S_CTRL, 0);
    repeat (3) @(negedge clk);
    drain("R8 missing pulses ch2");

    summary();
    $finish;
  end

endmodule